// File: doc/BRIEF.md
# Loadable One-Shot Countdown Timer

This block is a countdown timer governed by a three-state control machine. A host first writes a delay count with a load strobe. This parks the timer in a ready state, where it holds the count and does nothing more. A separate start strobe then launches the countdown. While the countdown runs, a stop strobe can abandon it early. A countdown that completes returns the machine to idle and raises a single-cycle expire pulse. A countdown that is stopped returns the machine to idle without a pulse.

The host always sees the current state of the machine and a running flag. Because loading and starting are separate steps, a count can be prepared well ahead of the event that triggers it. Once started, the delay is exact: a loaded value N gives N cycles of running before the expire pulse. A loaded value of zero is treated as one.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, state_o is 0 (idle), running_o is 0 and expire_o is 0.
- R2: state_o encodes idle as 0, ready as 1 and running as 2, and never shows 3. A load in idle moves the timer to ready on the next cycle.
- R3: A start strobe in idle is ignored: the state stays 0 and running_o stays 0.
- R4: A load in ready replaces the stored count. A later start runs for the new count.
- R5: A start in ready with stored count N makes running_o high (state 2) for exactly N cycles from the cycle after the start edge. On the following cycle, expire_o is high for one cycle and the state is 0.
- R6: A loaded value of 0 behaves as 1: one cycle of running, then expire.
- R7: A stop strobe while running returns the state to 0 on the next cycle, and expire_o does not pulse.
- R8: If stop arrives in the last running cycle, stop wins: the state goes to 0 and expire_o stays low.
- R9: While running, load and start strobes are ignored, and the countdown length is unchanged. In ready, a stop strobe is ignored and the state stays 1.
- R10: If load and start arrive together in ready, start wins and the previously stored count is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe, captures load_val_i |
| load_val_i | input | CNT_W | Delay count in cycles (0 acts as 1) |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| expire_o | output | 1 | One-cycle pulse when the countdown completes |
| running_o | output | 1 | High while in the running state |
| state_o | output | 2 | Current state: 0 idle, 1 ready, 2 running |

## Verification
Two events can land in the same cycle: an early stop and the natural end of the countdown. The bench forces this collision by loading a count of 3, starting, and driving stop in the third running cycle, which is exactly when the count is at its final value. The result is judged at the ports: the state must be idle on the next cycle and expire_o must stay low. A second collision, load together with start in ready, is judged by the length of the run that follows.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             expire_o,
  output logic             running_o,
  output logic [1:0]       state_o
);
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_READY = 2'd1;
  localparam logic [1:0] ST_RUN   = 2'd2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  wire             last_w   = (cnt_q == ONE);
  wire [CNT_W-1:0] ld_val_w = (load_val_i == '0) ? ONE : load_val_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (load_i) begin
            cnt_q <= ld_val_w;
            st_q  <= ST_READY;
          end
        end
        ST_READY: begin
          if (start_i)     st_q  <= ST_RUN;
          else if (load_i) cnt_q <= ld_val_w;
        end
        ST_RUN: begin
          if (stop_i) begin
            st_q <= ST_IDLE;
          end else if (last_w) begin
            st_q  <= ST_IDLE;
            exp_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign expire_o  = exp_q;
  assign running_o = (st_q == ST_RUN);
  assign state_o   = st_q;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             expire_o,
  input logic             running_o,
  input logic [1:0]       state_o
);
  a_r2_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  a_r2_load_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && load_i) |=> state_o == 2'd1);

  a_r3_start_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && start_i && !load_i) |=> (state_o == 2'd0 && !running_o));

  a_r5_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  a_r5_expire_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire_o) |-> (state_o == 2'd0 && $past(running_o)));

  a_r7_stop_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && stop_i) |=> (state_o == 2'd0 && !expire_o));

  a_r9_ready_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && stop_i && !start_i) |=> state_o == 2'd1);
endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
  .start_i(start_i), .stop_i(stop_i), .expire_o(expire_o),
  .running_o(running_o), .state_o(state_o)
);

// File: tb/oneshot_timer_bench.sv
module oneshot_timer_bench;
  localparam int W = 16;
  localparam int NV = 6;
  localparam int VLOAD [NV] = '{5, 1, 0, 3, 9, 2};
  localparam int VEXP  [NV] = '{5, 1, 1, 3, 9, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic expire_o, running_o;
  logic [1:0] state_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  oneshot_timer #(.CNT_W(W)) u_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .start_i(start_i), .stop_i(stop_i), .expire_o(expire_o),
    .running_o(running_o), .state_o(state_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load_i = 1'b1; load_val_i = W'(v);
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Counts running negedges from the current one; returns expire seen after.
  task automatic wait_done(output int n, output logic ex);
    n = 0;
    while (running_o && n < 1000) begin
      n++;
      if (expire_o) check(0, "R5 early expire", 1, 0);
      @(negedge clk);
    end
    ex = expire_o;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      check(0, "watchdog", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic ex;
    repeat (3) @(negedge clk);
    check(state_o == 2'd0 && !running_o && !expire_o, "R1 reset", state_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: start in idle ignored
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(state_o == 2'd0 && !running_o, "R3 start in idle", state_o, 0);

    // Table walk: R2, R5, R6
    for (int i = 0; i < NV; i++) begin
      do_load(VLOAD[i]);
      check(state_o == 2'd1, "R2 load to ready", state_o, 1);
      do_start();
      check(state_o == 2'd2, "R5 running state", state_o, 2);
      wait_done(n, ex);
      check(n == VEXP[i], (VLOAD[i] == 0) ? "R6 zero load length" : "R5 run length", n, VEXP[i]);
      check(ex === 1'b1 && state_o == 2'd0, "R5 expire pulse", ex, 1);
      @(negedge clk);
      check(!expire_o, "R5 expire one cycle", expire_o, 0);
    end

    // R9: stop in ready ignored
    do_load(4);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check(state_o == 2'd1, "R9 stop in ready", state_o, 1);

    // R4: reload in ready
    do_load(2);
    do_start();
    wait_done(n, ex);
    check(n == 2 && ex, "R4 reload in ready", n, 2);

    // R10: load and start together in ready
    do_load(3);
    load_i = 1'b1; load_val_i = W'(7); start_i = 1'b1;
    @(negedge clk); load_i = 1'b0; start_i = 1'b0;
    wait_done(n, ex);
    check(n == 3 && ex, "R10 start beats load", n, 3);

    // R7: early stop
    do_load(10);
    do_start();
    repeat (2) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check(state_o == 2'd0 && !expire_o, "R7 stop state", state_o, 0);
    ex = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (expire_o) ex = 1'b1;
    end
    check(!ex, "R7 no later expire", ex, 0);

    // R8: stop on final count cycle
    do_load(3);
    do_start();
    repeat (2) @(negedge clk);
    check(running_o, "R8 still running", running_o, 1);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check(state_o == 2'd0 && !expire_o, "R8 stop wins", expire_o, 0);
    @(negedge clk);
    check(!expire_o, "R8 no late expire", expire_o, 0);

    // R9: load and start ignored while running
    do_load(8);
    do_start();
    load_i = 1'b1; load_val_i = W'(2); start_i = 1'b1;
    @(negedge clk); load_i = 1'b0; start_i = 1'b0;
    wait_done(n, ex);
    check(n + 1 == 8 && ex, "R9 running ignores cmds", n + 1, 8);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule